// File: doc/BRIEF.md
# Receive Buffer with Per-Byte Error Tags

This block holds received characters between a serial receiver and the processor's read port. Every byte is stored beside a four-bit error tag in a store that runs in parallel with the data. Errors such as overrun, parity, framing and break stay hidden while the byte is queued. They are folded into a sticky status register only in the cycle after the processor pops that byte. The processor clears the status register by reading it.

The buffer can run as a queue of `DEPTH` entries or, with the queue switched off, as a single holding register. A trigger level raises a receive interrupt once enough bytes are waiting. The block also reports its fill level, a full flag and a ready flag. A flush input empties the buffer without disturbing the status register. The read data is show-ahead: `rdData` always presents the oldest byte while `rxReady` is high.

Top module: `rx_tag_fifo`

## Requirements
- R1: After reset, `fill` is 0 and `full`, `rxReady`, `rxIrq` and `errStatus` are all 0.
- R2: Bytes leave in arrival order, and `rdData` shows the oldest stored byte whenever `fill` is nonzero. A push and a pop in the same cycle leave `fill` unchanged.
- R3: `fill` counts the stored bytes. `full` is high when `fill` equals the capacity, which is `DEPTH` with the queue on and 1 with it off. A push is accepted only when `full` was low before that edge.
- R4: `rxReady` is high exactly when `fill` is nonzero.
- R5: A byte's error tag reaches `errStatus` only in the cycle after that byte is popped, and it is OR-ed into the bits already set. The status bits are: bit 0 overrun, bit 1 parity, bit 2 framing, bit 3 break. On input, `rxErr[0]` is parity, `rxErr[1]` framing and `rxErr[2]` break.
- R6: A pulse on `errRdEn` clears `errStatus` at the next edge. Bits merged at that same edge (from a pop or a direct overrun) survive the clear.
- R7: With the queue on, a byte that arrives while `full` is high is dropped. The overrun bit is set on the newest stored entry.
- R8: With the queue off, a byte that arrives while the holding register is occupied is dropped. Bit 0 of `errStatus` is set at that edge.
- R9: With the queue on, `rxIrq` is high while `fill` is nonzero and at least `trigLevel`. With the queue off, it is high while a byte is held.
- R10: `swReset` empties the buffer at the next edge and discards pending tags, and it overrides a push or pop in the same cycle. `errStatus` is only cleared by `errRdEn`.
- R11: A pop request while empty changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| fifoEn | input | 1 | 1: queue of DEPTH entries; 0: single holding register |
| swReset | input | 1 | Flush buffer contents |
| trigLevel | input | CW | Interrupt trigger level |
| rxValid | input | 1 | Receiver delivers a byte this cycle |
| rxData | input | DATA_W | Received byte |
| rxErr | input | 3 | Per-byte errors: [0] parity, [1] framing, [2] break |
| rdEn | input | 1 | Pop the oldest byte |
| rdData | output | DATA_W | Oldest stored byte (show-ahead) |
| errRdEn | input | 1 | Read-and-clear of the error status |
| errStatus | output | 4 | Sticky error status: [0] overrun, [1] parity, [2] framing, [3] break |
| rxReady | output | 1 | At least one byte available |
| rxIrq | output | 1 | Receive interrupt |
| fill | output | CW | Number of stored bytes |
| full | output | 1 | Buffer at capacity |

## Verification
A pointer or counter that drifts from the true contents shows up at once in `fill`, `rxReady` or `full`. It also shows a wrong `rdData` on the next pop after the fault. A tag written to the wrong entry stays hidden until the affected byte reaches the head. It then appears as a missing or misplaced `errStatus` bit in the cycle after that pop, possibly many cycles after the fault. For that reason the reference model compares `errStatus` on every cycle, across long runs that fill the buffer completely.

// File: rtl/rtf_pkg.sv
package rtf_pkg;
  // Error tag kept beside every stored byte; bit 0 is overrun.
  typedef struct packed {
    logic brk;
    logic frm;
    logic par;
    logic ovr;
  } errTag_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic flush;
    logic push;
    logic pop;
    logic tagOvr;
  } strobe_t;
endpackage

// File: rtl/rtf_ctrl.sv
module rtf_ctrl
  import rtf_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          fifoEn,
  input  logic          swReset,
  input  logic [CW-1:0] trigLevel,
  input  logic          rxValid,
  input  logic          rdEn,
  input  logic          errRdEn,
  input  errTag_t       headTag,
  output strobe_t       strobe,
  output logic [CW-1:0] fill,
  output logic          full,
  output logic          rxReady,
  output logic          rxIrq,
  output logic [3:0]    errStatus
);
  logic [CW-1:0] count;
  logic [CW-1:0] capacity;
  logic          directOvr;
  logic [3:0]    statusNext;

  assign capacity = fifoEn ? CW'(DEPTH) : CW'(1);
  assign full     = (count >= capacity);
  assign fill     = count;
  assign rxReady  = (count != '0);
  assign rxIrq    = rxReady && (!fifoEn || (count >= trigLevel));

  always_comb begin
    strobe.flush  = swReset;
    strobe.pop    = !swReset && rdEn && rxReady;
    strobe.push   = !swReset && rxValid && !full;
    strobe.tagOvr = !swReset && rxValid && full && fifoEn;
    directOvr     = !swReset && rxValid && full && !fifoEn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (strobe.flush) begin
      count <= '0;
    end else begin
      case ({strobe.push, strobe.pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  // Clear-on-read status; merges from the same edge win over the clear.
  always_comb begin
    statusNext = errRdEn ? 4'b0000 : errStatus;
    if (strobe.pop) statusNext = statusNext | headTag;
    if (directOvr)  statusNext[0] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) errStatus <= '0;
    else       errStatus <= statusNext;
  end
endmodule

// File: rtl/rtf_data.sv
module rtf_data
  import rtf_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [DATA_W-1:0] wrData,
  input  errTag_t           wrTag,
  output logic [DATA_W-1:0] rdData,
  output errTag_t           headTag
);
  logic [DATA_W-1:0] dataMem [DEPTH];
  errTag_t           tagMem  [DEPTH];
  logic [AW-1:0]     wrPtr;
  logic [AW-1:0]     rdPtr;
  logic [AW-1:0]     lastPtr;

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign lastPtr = (wrPtr == '0) ? AW'(DEPTH - 1) : wrPtr - AW'(1);
  assign rdData  = dataMem[rdPtr];
  assign headTag = tagMem[rdPtr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else if (strobe.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobe.push) wrPtr <= nextPtr(wrPtr);
      if (strobe.pop)  rdPtr <= nextPtr(rdPtr);
    end
  end

  // Push and overrun tagging never coincide: one needs room, the other a full store.
  always_ff @(posedge clk) begin
    if (strobe.push) begin
      dataMem[wrPtr] <= wrData;
      tagMem[wrPtr]  <= wrTag;
    end
    if (strobe.tagOvr) tagMem[lastPtr].ovr <= 1'b1;
  end
endmodule

// File: rtl/rx_tag_fifo.sv
module rx_tag_fifo
  import rtf_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fifoEn,
  input  logic              swReset,
  input  logic [CW-1:0]     trigLevel,
  input  logic              rxValid,
  input  logic [DATA_W-1:0] rxData,
  input  logic [2:0]        rxErr,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  input  logic              errRdEn,
  output logic [3:0]        errStatus,
  output logic              rxReady,
  output logic              rxIrq,
  output logic [CW-1:0]     fill,
  output logic              full
);
  strobe_t strobe;
  errTag_t headTag;
  errTag_t wrTag;

  assign wrTag = '{brk: rxErr[2], frm: rxErr[1], par: rxErr[0], ovr: 1'b0};

  rtf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .fifoEn(fifoEn), .swReset(swReset),
    .trigLevel(trigLevel), .rxValid(rxValid), .rdEn(rdEn), .errRdEn(errRdEn),
    .headTag(headTag), .strobe(strobe), .fill(fill), .full(full),
    .rxReady(rxReady), .rxIrq(rxIrq), .errStatus(errStatus)
  );

  rtf_data #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(rxData),
    .wrTag(wrTag), .rdData(rdData), .headTag(headTag)
  );
endmodule

// File: rtl/rx_tag_fifo_chk.sv
module rx_tag_fifo_chk #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              fifoEn,
  input logic              swReset,
  input logic [CW-1:0]     trigLevel,
  input logic              rxValid,
  input logic [DATA_W-1:0] rxData,
  input logic [2:0]        rxErr,
  input logic              rdEn,
  input logic [DATA_W-1:0] rdData,
  input logic              errRdEn,
  input logic [3:0]        errStatus,
  input logic              rxReady,
  input logic              rxIrq,
  input logic [CW-1:0]     fill,
  input logic              full
);
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    fill <= CW'(DEPTH));

  a_r4_ready_after_push: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !full && !swReset) |=> rxReady);

  a_r6_clear_on_read: assert property (@(posedge clk) disable iff (!rstN)
    (errRdEn && !rdEn && !(rxValid && full)) |=> (errStatus == 4'b0000));

  a_r5_status_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!rdEn && !errRdEn && !(rxValid && full)) |=> $stable(errStatus));

  a_r10_flush_empties: assert property (@(posedge clk) disable iff (!rstN)
    swReset |=> (fill == '0));

  a_r11_empty_pop: assert property (@(posedge clk) disable iff (!rstN)
    (fill == '0 && rdEn && !rxValid) |=> (fill == '0));

  a_r9_irq_needs_data: assert property (@(posedge clk) disable iff (!rstN)
    rxIrq |-> rxReady);
endmodule

bind rx_tag_fifo rx_tag_fifo_chk #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/rx_tag_fifo_tb.sv
`timescale 1ns/1ps
module rx_tag_fifo_tb;
  localparam int DEPTH  = 16;
  localparam int DATA_W = 8;
  localparam int CW     = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic fifoEn = 1'b1, swReset = 1'b0, rxValid = 1'b0, rdEn = 1'b0, errRdEn = 1'b0;
  logic [CW-1:0] trigLevel = CW'(4);
  logic [DATA_W-1:0] rxData = '0;
  logic [2:0] rxErr = '0;
  logic [DATA_W-1:0] rdData;
  logic [3:0] errStatus;
  logic rxReady, rxIrq, full;
  logic [CW-1:0] fill;

  int checks = 0;
  int errors = 0;

  // Reference model: entries are {tag[3:0], data[7:0]}, tag bit 0 = overrun.
  logic [11:0] q[$];
  logic [3:0]  st = '0;

  always #4 clk = ~clk;

  rx_tag_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rstN(rstN), .fifoEn(fifoEn), .swReset(swReset),
    .trigLevel(trigLevel), .rxValid(rxValid), .rxData(rxData), .rxErr(rxErr),
    .rdEn(rdEn), .rdData(rdData), .errRdEn(errRdEn), .errStatus(errStatus),
    .rxReady(rxReady), .rxIrq(rxIrq), .fill(fill), .full(full)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int capOf();
    return fifoEn ? DEPTH : 1;
  endfunction

  task automatic compareAll();
    int n = q.size();
    chk("R3", "fill", int'(fill), n);
    chk("R3", "full", int'(full), int'(n >= capOf()));
    chk("R4", "rxReady", int'(rxReady), int'(n > 0));
    chk("R9", "rxIrq", int'(rxIrq), int'(n > 0 && (!fifoEn || n >= int'(trigLevel))));
    chk("R5/R6/R8", "errStatus", int'(errStatus), int'(st));
    if (n > 0) chk("R2", "rdData", int'(rdData), int'(q[0][7:0]));
  endtask

  task automatic modelEdge();
    int n = q.size();
    bit isFull = (n >= capOf());
    logic [3:0] nst = errRdEn ? 4'b0 : st;
    if (swReset) begin
      q.delete();                                  // R10
    end else begin
      if (rxValid && isFull) begin
        if (fifoEn) begin
          if (n > 0) q[n-1][8] = 1'b1;             // R7
        end else nst[0] = 1'b1;                    // R8
      end
      if (rdEn && q.size() > 0) begin
        nst = nst | q[0][11:8];                    // R5
        void'(q.pop_front());
      end
      if (rxValid && !isFull) q.push_back({rxErr, 1'b0, rxData});
    end
    st = nst;
  endtask

  task automatic step(input bit v, input logic [7:0] d, input logic [2:0] e,
                      input bit rd, input bit er, input bit sr);
    rxValid = v; rxData = d; rxErr = e; rdEn = rd; errRdEn = er; swReset = sr;
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    compareAll();
  endtask

  task automatic idle();
    step(0, 8'h00, 3'b000, 0, 0, 0);
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1", "fill", int'(fill), 0);
    chk("R1", "full", int'(full), 0);
    chk("R1", "rxReady", int'(rxReady), 0);
    chk("R1", "rxIrq", int'(rxIrq), 0);
    chk("R1", "errStatus", int'(errStatus), 0);

    // R2/R9: three clean bytes below trigger, then reach trigger
    step(1, 8'h11, 3'b000, 0, 0, 0);
    step(1, 8'h22, 3'b000, 0, 0, 0);
    step(1, 8'h33, 3'b000, 0, 0, 0);
    step(1, 8'h44, 3'b000, 0, 0, 0);
    // R5: tagged bytes parity, framing, break
    step(1, 8'h55, 3'b001, 0, 0, 0);
    step(1, 8'h66, 3'b010, 0, 0, 0);
    step(1, 8'h77, 3'b100, 0, 0, 0);
    idle();
    for (int i = 0; i < 5; i++) step(0, 8'h00, 3'b000, 1, 0, 0);
    chk("R5", "parity after pop", int'(errStatus), 4'b0010);
    // R6: clear and pop of a framing byte in the same cycle
    step(0, 8'h00, 3'b000, 1, 1, 0);
    chk("R6", "merge beats clear", int'(errStatus), 4'b0100);
    step(0, 8'h00, 3'b000, 0, 1, 0);
    chk("R6", "cleared", int'(errStatus), 0);
    step(0, 8'h00, 3'b000, 1, 0, 0);
    chk("R5", "break after pop", int'(errStatus), 4'b1000);
    // R11: pop on empty
    step(0, 8'h00, 3'b000, 1, 1, 0);
    step(0, 8'h00, 3'b000, 1, 0, 0);
    chk("R11", "fill stays 0", int'(fill), 0);

    // R3/R7: fill to capacity, overrun tags the newest
    for (int i = 0; i < DEPTH; i++) step(1, 8'(8'hA0 + i), 3'b000, 0, 0, 0);
    chk("R3", "full at DEPTH", int'(full), 1);
    step(1, 8'hEE, 3'b000, 0, 0, 0);
    chk("R7", "drop keeps fill", int'(fill), DEPTH);
    step(1, 8'hEF, 3'b000, 1, 0, 0);   // full + pop: still dropped
    step(1, 8'hF0, 3'b010, 1, 0, 0);   // room now: push + pop together (R2)
    for (int i = 0; i < DEPTH; i++) step(0, 8'h00, 3'b000, 1, 0, 0);
    chk("R7", "overrun seen", int'(errStatus[0]), 1);
    step(0, 8'h00, 3'b000, 0, 1, 0);

    // R10: flush overrides push and pop
    for (int i = 0; i < 5; i++) step(1, 8'(i), 3'b111, 0, 0, 0);
    step(1, 8'h99, 3'b000, 1, 0, 1);
    chk("R10", "flushed", int'(fill), 0);
    step(1, 8'h5A, 3'b000, 0, 0, 0);
    step(0, 8'h00, 3'b000, 1, 0, 0);
    chk("R10", "stale tag gone", int'(errStatus), 0);

    // R8: holding-register mode
    fifoEn = 1'b0;
    step(0, 8'h00, 3'b000, 0, 0, 1);
    step(1, 8'hC3, 3'b000, 0, 0, 0);
    chk("R8", "full at one", int'(full), 1);
    step(1, 8'hC4, 3'b000, 0, 0, 0);
    chk("R8", "direct overrun", int'(errStatus), 4'b0001);
    step(0, 8'h00, 3'b000, 1, 1, 0);

    // Random traffic, queue on then off
    fifoEn = 1'b1;
    step(0, 8'h00, 3'b000, 0, 0, 1);
    for (int i = 0; i < 3000; i++) begin
      if (i % 500 == 0) trigLevel = CW'($urandom_range(0, DEPTH));
      step($urandom_range(0, 99) < 55, 8'($urandom), 3'($urandom_range(0, 7) & ($urandom_range(0, 3) == 0 ? 7 : 0)),
           $urandom_range(0, 99) < 45, $urandom_range(0, 9) == 0, $urandom_range(0, 199) == 0);
    end
    fifoEn = 1'b0;
    step(0, 8'h00, 3'b000, 0, 0, 1);
    for (int i = 0; i < 1000; i++) begin
      step($urandom_range(0, 1) == 1, 8'($urandom), 3'($urandom_range(0, 7)),
           $urandom_range(0, 2) == 0, $urandom_range(0, 4) == 0, $urandom_range(0, 99) == 0);
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule